// File: doc/BRIEF.md
# Dual-Mode Programmable Loop Divider

This block divides a local-oscillator clock by a programmed divisor N and feeds the resulting pulse train to a PLL phase comparator. Two control bits pick one of three counting paths. With the band bit set, a fixed divide-by-two stage sits ahead of the main counter, so the total division is 2N. With the band bit clear, the swallow-select bit chooses between the wide counter at full input rate, with N used as given, and a 12-bit programmable counter for small divisors.

A divisor outside the legal range of the active path is forced to the nearest limit, and a flag reports that this happened. A new divisor or mode is captured only at terminal count, so the period in progress always finishes with its old setting. Control is a two-state machine. ST_LOAD is entered on reset and captures the first divisor. The transition load_done goes from ST_LOAD to ST_COUNT unconditionally. In ST_COUNT the transition reload stays in ST_COUNT: at terminal count it captures new settings and fires the output pulse.

Top module: `ldiv_top`

## Requirements
- R1: With band_hi = 1, div_pulse repeats every 2N input cycles, whatever the value of swallow_sel. In this mode the legal N range is 272 to 65535.
- R2: With band_hi = 0 and swallow_sel = 1, div_pulse repeats every N input cycles, with N legal from 272 to 65535.
- R3: With band_hi = 0 and swallow_sel = 0, div_pulse repeats every N input cycles, with N legal from 4 to 4095.
- R4: A divisor below the active minimum is replaced by that minimum (272, or 4 in the 12-bit mode), and clamp_flag reads 1.
- R5: In the 12-bit mode, a divisor above 4095 is replaced by 4095, and clamp_flag reads 1.
- R6: clamp_flag describes the divisor in use. It changes only in the cycle that div_pulse goes high, and it reads 0 for an in-range divisor.
- R7: A change of div_word, band_hi or swallow_sel has no effect on the period in progress. The change applies from the next terminal count.
- R8: div_pulse is high for exactly one input cycle per period.
- R9: While rst is high, div_pulse and clamp_flag are 0. The first rising clock edge after release loads the divisor. The first pulse rises N edges (2N when prescaled) after that loading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Local-oscillator input clock |
| rst | input | 1 | Synchronous reset, active high |
| div_word | input | 16 | Programmed divisor N |
| band_hi | input | 1 | 1 selects the prescaled path |
| swallow_sel | input | 1 | With band_hi = 0: 1 selects the wide counter, 0 selects the 12-bit counter |
| div_pulse | output | 1 | One-cycle pulse per division period |
| clamp_flag | output | 1 | The divisor in use was clamped |

## Verification
A setting applied mid-period first shows at the next terminal count. The bench therefore waits for one pulse after any change, checks clamp_flag in that same sampled cycle, and then counts falling edges up to the following pulse to get the period. For R7, the interval counted right after a change must still equal the old period, and the interval after that must equal the new one. After reset release, the first pulse is due on the sixth falling edge for N = 5: one edge to load the divisor and five to count it down. All samples are taken on the falling edge.

// File: rtl/ldiv_pkg.sv
package ldiv_pkg;
    typedef enum logic [1:0] {
        MD_DIRECT    = 2'd0,
        MD_SWALLOW   = 2'd1,
        MD_PRESCALED = 2'd2
    } ldiv_mode_e;

    typedef enum logic {
        ST_LOAD  = 1'b0,
        ST_COUNT = 1'b1
    } ldiv_state_e;
endpackage

// File: rtl/ldiv_clamp.sv
module ldiv_clamp
    import ldiv_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int DIR_W   = 12,
    parameter int SW_MIN  = 272,
    parameter int DIR_MIN = 4
) (
    input  logic             band_hi,
    input  logic             swallow_sel,
    input  logic [CNT_W-1:0] div_word,
    output ldiv_mode_e       mode_o,
    output logic [CNT_W-1:0] n_o,
    output logic             clamped_o
);
    localparam logic [CNT_W-1:0] SW_MIN_V  = CNT_W'(SW_MIN);
    localparam logic [CNT_W-1:0] SW_MAX_V  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] DIR_MIN_V = CNT_W'(DIR_MIN);
    localparam logic [CNT_W-1:0] DIR_MAX_V = CNT_W'((1 << DIR_W) - 1);

    logic [CNT_W-1:0] lo, hi;

    always_comb begin
        if (band_hi)          mode_o = MD_PRESCALED;
        else if (swallow_sel) mode_o = MD_SWALLOW;
        else                  mode_o = MD_DIRECT;

        lo = (mode_o == MD_DIRECT) ? DIR_MIN_V : SW_MIN_V;
        hi = (mode_o == MD_DIRECT) ? DIR_MAX_V : SW_MAX_V;

        if (div_word < lo) begin
            n_o       = lo;
            clamped_o = 1'b1;
        end else if (div_word > hi) begin
            n_o       = hi;
            clamped_o = 1'b1;
        end else begin
            n_o       = div_word;
            clamped_o = 1'b0;
        end
    end
endmodule

// File: rtl/ldiv_prescale.sv
module ldiv_prescale
    import ldiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  ldiv_mode_e mode,
    output logic       tick
);
    logic tog;

    always_ff @(posedge clk) begin
        if (rst || restart) tog <= 1'b0;
        else                tog <= ~tog;
    end

    assign tick = (mode == MD_PRESCALED) ? tog : 1'b1;

    // R1: with the prescaler active, counter steps never come back to back
    a_r1_half_rate: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_PRESCALED && tick && !restart) |=> !tick);
endmodule

// File: rtl/ldiv_count.sv
module ldiv_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             tick,
    input  logic [CNT_W-1:0] n_in,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);
    always_ff @(posedge clk) begin
        if (rst)                    cnt <= '0;
        else if (load)              cnt <= n_in - CNT_W'(1);
        else if (tick && cnt != '0) cnt <= cnt - CNT_W'(1);
    end

    assign zero = (cnt == '0);

    // R7: a step with no load moves the count down by exactly one
    a_r7_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (!load && tick && !zero) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/ldiv_top.sv
module ldiv_top
    import ldiv_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int DIR_W   = 12,
    parameter int SW_MIN  = 272,
    parameter int DIR_MIN = 4
) (
    input  logic             osc_clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] div_word,
    input  logic             band_hi,
    input  logic             swallow_sel,
    output logic             div_pulse,
    output logic             clamp_flag
);
    localparam logic [CNT_W-1:0] DIR_MAX_V = CNT_W'((1 << DIR_W) - 1);

    ldiv_state_e      st, st_nxt;
    ldiv_mode_e       md_cl, act_mode;
    logic [CNT_W-1:0] n_cl, act_n, cnt;
    logic             cl, tick, zero, reload, load;

    ldiv_clamp #(.CNT_W(CNT_W), .DIR_W(DIR_W), .SW_MIN(SW_MIN), .DIR_MIN(DIR_MIN)) u_clamp (
        .band_hi(band_hi), .swallow_sel(swallow_sel), .div_word(div_word),
        .mode_o(md_cl), .n_o(n_cl), .clamped_o(cl)
    );

    ldiv_prescale u_pre (
        .clk(osc_clk), .rst(rst), .restart(load), .mode(act_mode), .tick(tick)
    );

    ldiv_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(osc_clk), .rst(rst), .load(load), .tick(tick),
        .n_in(n_cl), .cnt(cnt), .zero(zero)
    );

    assign reload = (st == ST_COUNT) && tick && zero;
    assign load   = (st == ST_LOAD) || reload;

    always_comb begin
        unique case (st)
            ST_LOAD:  st_nxt = ST_COUNT;
            ST_COUNT: st_nxt = ST_COUNT;
            default:  st_nxt = ST_LOAD;
        endcase
    end

    always_ff @(posedge osc_clk) begin
        if (rst) st <= ST_LOAD;
        else     st <= st_nxt;
    end

    always_ff @(posedge osc_clk) begin
        if (rst) begin
            act_n      <= '0;
            act_mode   <= MD_DIRECT;
            clamp_flag <= 1'b0;
            div_pulse  <= 1'b0;
        end else begin
            div_pulse <= reload;
            if (load) begin
                act_n      <= n_cl;
                act_mode   <= md_cl;
                clamp_flag <= cl;
            end
        end
    end

    // R8: the output pulse lasts a single input cycle
    a_r8_one_cycle: assert property (@(posedge osc_clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    // R7: between terminal counts the captured settings stay unchanged
    a_r7_hold_settings: assert property (@(posedge osc_clk) disable iff (rst)
        (st == ST_COUNT && !reload) |=> ($stable(act_n) && $stable(act_mode) && $stable(clamp_flag)));

    // R4 and R5: the divisor in use always lies inside the active mode's range
    a_r4_in_range: assert property (@(posedge osc_clk) disable iff (rst)
        (st == ST_COUNT) |-> ((act_mode == MD_DIRECT)
            ? (act_n >= CNT_W'(DIR_MIN) && act_n <= DIR_MAX_V)
            : (act_n >= CNT_W'(SW_MIN))));

    // R3: the count stays below the divisor in use
    a_r3_count_bound: assert property (@(posedge osc_clk) disable iff (rst)
        (st == ST_COUNT) |-> (cnt < act_n));

    // R9: the outputs are clear in the first cycle after reset
    a_r9_reset_clear: assert property (@(posedge osc_clk) disable iff (rst)
        $past(rst) |-> (!div_pulse && !clamp_flag));
endmodule

// File: tb/tb_ldiv_top.sv
`timescale 1ns/1ps
module tb_ldiv_top;
    logic        osc_clk = 1'b0;
    logic        rst;
    logic [15:0] div_word;
    logic        band_hi, swallow_sel;
    logic        div_pulse, clamp_flag;

    int checks = 0;
    int errors = 0;

    always #2 osc_clk = ~osc_clk;

    ldiv_top dut (
        .osc_clk(osc_clk), .rst(rst), .div_word(div_word),
        .band_hi(band_hi), .swallow_sel(swallow_sel),
        .div_pulse(div_pulse), .clamp_flag(clamp_flag)
    );

    typedef struct packed {
        logic        band;
        logic        sel;
        logic [15:0] n;
        logic [17:0] period;
        logic        flag;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 16'd300,   18'd600,  1'b0},
        '{1'b1, 1'b1, 16'd280,   18'd560,  1'b0},
        '{1'b1, 1'b0, 16'd100,   18'd544,  1'b1},
        '{1'b0, 1'b1, 16'd272,   18'd272,  1'b0},
        '{1'b0, 1'b1, 16'd1000,  18'd1000, 1'b0},
        '{1'b0, 1'b1, 16'd5,     18'd272,  1'b1},
        '{1'b0, 1'b0, 16'd4,     18'd4,    1'b0},
        '{1'b0, 1'b0, 16'd4095,  18'd4095, 1'b0},
        '{1'b0, 1'b0, 16'd3,     18'd4,    1'b1},
        '{1'b0, 1'b0, 16'd5000,  18'd4095, 1'b1},
        '{1'b0, 1'b0, 16'd0,     18'd4,    1'b1},
        '{1'b0, 1'b0, 16'd37,    18'd37,   1'b0}
    };

    function automatic string vtag(int i);
        case (i)
            0, 1:    return "R1";
            2, 5:    return "R4";
            3, 4:    return "R2";
            6, 7:    return "R3";
            8, 10:   return "R4";
            9:       return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // step past the current cycle, then wait until div_pulse is seen high
    task automatic wait_pulse();
        @(negedge osc_clk);
        while (!div_pulse) @(negedge osc_clk);
    endtask

    // count falling edges from the present pulse to the next one
    task automatic count_to_next(output int per);
        per = 0;
        do begin
            @(negedge osc_clk);
            per++;
        end while (!div_pulse);
    endtask

    initial begin
        repeat (200000) @(posedge osc_clk);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int per;
        rst = 1'b1;
        div_word = 16'd5;
        band_hi = 1'b0;
        swallow_sel = 1'b0;
        repeat (4) @(negedge osc_clk);
        check("R9 pulse in reset", int'(div_pulse), 0);
        check("R9 flag in reset", int'(clamp_flag), 0);

        // R9: release, then the first pulse is due six falling edges later
        rst = 1'b0;
        per = 0;
        do begin
            @(negedge osc_clk);
            per++;
        end while (!div_pulse && per < 100);
        check("R9 first pulse", per, 6);
        @(negedge osc_clk);
        check("R8 pulse width", int'(div_pulse), 0);

        for (int i = 0; i < NV; i++) begin
            band_hi = VEC[i].band;
            swallow_sel = VEC[i].sel;
            div_word = VEC[i].n;
            wait_pulse();
            check({vtag(i), " clamp_flag"}, int'(clamp_flag), int'(VEC[i].flag));
            count_to_next(per);
            check({vtag(i), " period"}, per, int'(VEC[i].period));
        end

        // R7: a divisor change mid-period leaves the current period alone
        band_hi = 1'b0; swallow_sel = 1'b0; div_word = 16'd10;
        wait_pulse();
        count_to_next(per);
        check("R7 settle", per, 10);
        div_word = 16'd20;
        count_to_next(per);
        check("R7 old period kept", per, 10);
        count_to_next(per);
        check("R7 new period", per, 20);

        // R7: a mode change also waits for terminal count
        band_hi = 1'b1; div_word = 16'd272;
        count_to_next(per);
        check("R7 old mode kept", per, 20);
        count_to_next(per);
        check("R7 prescaled after switch", per, 544);
        @(negedge osc_clk);
        check("R8 pulse width prescaled", int'(div_pulse), 0);

        // R6: the flag holds through the period while the input changes
        band_hi = 1'b0; swallow_sel = 1'b0; div_word = 16'd2;
        wait_pulse();
        check("R6 flag set on load", int'(clamp_flag), 1);
        div_word = 16'd50;
        repeat (2) @(negedge osc_clk);
        check("R6 flag held mid-period", int'(clamp_flag), 1);
        wait_pulse();
        check("R6 flag cleared on load", int'(clamp_flag), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule